// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a single-clock static memory with one shared bidirectional data bus, meant to sit beside a processor or cache controller with almost no glue logic. Every synchronous input is sampled on the rising clock edge. Either of two start strobes (one for the processor, one for the cache controller) opens a burst of up to four words. After that, an advance input steps an internal two-bit counter through the rest of the burst. The counter can walk in linear or interleaved order. Reads are flow-through: the word addressed at an edge drives the bus during the cycle that follows that edge, with no output register in between.

A word holds four byte lanes of nine bits each. A write can store all lanes at once, or only the lanes picked by per-lane enables. Three chip selects allow several devices to share one bus. Output enable and sleep are asynchronous: either one releases the bus at once. While sleep is high, accesses are ignored and the stored data is kept. The memory depth is a parameter, so the block can run small in simulation.

Top module: `fts_sram`

## Requirements
- R1: A low level on `cpu_start_n` or `ctl_start_n` at a rising edge starts a burst and captures `addr`. In cycles where both strobes are high, `addr` is ignored.
- R2: A burst start selects the device only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A deselected burst never drives `dq` and writes nothing.
- R3: On a start, the counter loads `addr[1:0]` and the beat index resets to 0. The index increments only at edges where `burst_adv_n`=0 and both strobes are high. Otherwise the index holds and the same word is accessed again.
- R4: With `order_il`=1, the low address bits are the start value XOR the beat index. With `order_il`=0, they are the start value plus the beat index, modulo 4. `addr[AW-1:2]` never changes within a burst.
- R5: The word for the address in effect at edge k drives `dq` after edge k and before edge k+1. This gives a 2-1-1-1 read burst.
- R6: A start on `cpu_start_n` is always a read, even when the write enables are active and `ctl_start_n` is low at the same time.
- R7: `wr_all_n`=0 writes all four lanes. Otherwise `wr_lane_en_n`=0 writes each lane i for which `lane_sel_n[i]`=0, where lane i is `dq[9i+8:9i]`. If neither condition holds, the cycle is a read.
- R8: The cycle after a write edge does not drive `dq`.
- R9: `out_en_n`=1 releases `dq` immediately, without waiting for a clock edge.
- R10: `sleep`=1 releases `dq` immediately. While it is high, edges cause no write and no counter change, and stored words are kept.
- R11: After reset, no read is active and `dq` is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | AW | Word address, captured at a burst start |
| dq | inout | 36 | Shared data bus: four 9-bit lanes |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| cpu_start_n | input | 1 | Processor burst start strobe (always a read) |
| ctl_start_n | input | 1 | Controller burst start strobe |
| burst_adv_n | input | 1 | Advance the burst counter, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep: bus released, accesses ignored |

## Verification
The hardest case to reach from the ports is an edge that must have no effect: a sleep-time write or counter advance, or a write through a deselected burst. Such an edge leaves no trace on the bus at the moment it happens. The bench therefore follows each one with a fresh, correctly selected burst to the same words, and shows through ordinary reads that the contents and the burst position were kept. Every burst-start offset is swept in both orders, and all sixteen lane masks are swept in multi-beat write bursts. The expected words are computed in the bench with XOR or modular addition on a shadow array.

// File: rtl/fts_pkg.sv
package fts_pkg;
   localparam int BURST_BITS = 2;

   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } burst_order_e;

   // low address bits of a given beat, from the captured start offset
   function automatic logic [BURST_BITS-1:0] beat_offset(
      input logic [BURST_BITS-1:0] start,
      input logic [BURST_BITS-1:0] beat,
      input burst_order_e          order
   );
      if (order == ORD_INTERLEAVED) return start ^ beat;
      return start + beat;
   endfunction
endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
   import fts_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  freeze,
   input  logic                  load,
   input  logic                  step,
   input  logic                  order_il,
   input  logic [AW-1:0]         ld_addr,
   output logic [AW-1:0]         nxt_addr,
   output logic [AW-1:0]         cur_addr,
   output logic [BURST_BITS-1:0] beat_q,
   output logic [AW-BURST_BITS-1:0] upper_q
);
   localparam int UW = AW - BURST_BITS;

   logic [BURST_BITS-1:0] base_q, base_d, beat_d;
   logic [UW-1:0]         upper_d;
   burst_order_e          order;

   assign order = burst_order_e'(order_il);

   always_comb begin
      base_d  = base_q;
      beat_d  = beat_q;
      upper_d = upper_q;
      if (!freeze) begin
         if (load) begin
            base_d  = ld_addr[BURST_BITS-1:0];
            upper_d = ld_addr[AW-1:BURST_BITS];
            beat_d  = '0;
         end else if (step) begin
            beat_d  = beat_q + 1'b1;
         end
      end
   end

   assign nxt_addr = {upper_d, beat_offset(base_d, beat_d, order)};
   assign cur_addr = {upper_q, beat_offset(base_q, beat_q, order)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         beat_q  <= '0;
         upper_q <= '0;
      end else begin
         base_q  <= base_d;
         beat_q  <= beat_d;
         upper_q <= upper_d;
      end
   end
endmodule

// File: rtl/fts_lane_bank.sv
module fts_lane_bank #(
   parameter int AW     = 8,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [LANE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
   import fts_pkg::*;
#(
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   inout  wire  [LANES*LANE_W-1:0] dq,
   input  logic                    cs0_n,
   input  logic                    cs1,
   input  logic                    cs2_n,
   input  logic                    cpu_start_n,
   input  logic                    ctl_start_n,
   input  logic                    burst_adv_n,
   input  logic                    wr_all_n,
   input  logic                    wr_lane_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    order_il,
   input  logic                    out_en_n,
   input  logic                    sleep
);
   localparam int DW = LANES * LANE_W;
   localparam int UW = AW - BURST_BITS;

   generate
      if (AW <= BURST_BITS) begin : g_bad_aw
         $error("fts_sram: AW must exceed the burst counter width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("fts_sram: lane count and lane width must be positive");
      end
   endgenerate

   logic                  cpu_start, start, step, cs_ok;
   logic                  sel_q, sel_nxt, rd_q, wr_cycle;
   logic [LANES-1:0]      wr_lanes, lane_we;
   logic [AW-1:0]         nxt_addr, cur_addr;
   logic [BURST_BITS-1:0] burst_beat;
   logic [UW-1:0]         burst_upper;
   logic [DW-1:0]         rdata;

   always_comb begin
      cpu_start = !cpu_start_n && !sleep;
      start     = (!cpu_start_n || !ctl_start_n) && !sleep;
      step      = !sleep && cpu_start_n && ctl_start_n && !burst_adv_n;
      cs_ok     = !cs0_n && cs1 && !cs2_n;
      sel_nxt   = start ? cs_ok : sel_q;
      if (!wr_all_n)          wr_lanes = '1;
      else if (!wr_lane_en_n) wr_lanes = ~lane_sel_n;
      else                    wr_lanes = '0;
      wr_cycle  = !sleep && sel_nxt && !cpu_start && (|wr_lanes);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         rd_q  <= 1'b0;
      end else begin
         sel_q <= sel_nxt;
         rd_q  <= !sleep && sel_nxt && !wr_cycle;
      end
   end

   fts_burst_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (sleep),
      .load     (start),
      .step     (step),
      .order_il (order_il),
      .ld_addr  (addr),
      .nxt_addr (nxt_addr),
      .cur_addr (cur_addr),
      .beat_q   (burst_beat),
      .upper_q  (burst_upper)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_we[g] = wr_cycle && wr_lanes[g];
         fts_lane_bank #(.AW(AW), .LANE_W(LANE_W)) u_bank (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (nxt_addr),
            .wdata (dq[g*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rdata (rdata[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign dq = (rd_q && !out_en_n && !sleep) ? rdata : {DW{1'bz}};
endmodule

// File: rtl/fts_chk.sv
module fts_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sleep,
   input logic          cpu_start_n,
   input logic          ctl_start_n,
   input logic          burst_adv_n,
   input logic          cs0_n,
   input logic          cs1,
   input logic          cs2_n,
   input logic [1:0]    beat,
   input logic [AW-3:0] upper,
   input logic          rd_q,
   input logic          wr_cycle
);
   // R3
   load_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!cpu_start_n || !ctl_start_n)) |=> (beat == 2'd0));

   // R3
   step_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cpu_start_n && ctl_start_n && !burst_adv_n)
      |=> (beat == $past(beat) + 2'd1));

   // R3
   hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cpu_start_n && ctl_start_n && burst_adv_n) |=> $stable(beat));

   // R4
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_start_n && ctl_start_n) |=> $stable(upper));

   // R2
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!cpu_start_n || !ctl_start_n) && (cs0_n || !cs1 || cs2_n))
      |=> !rd_q);

   // R6
   cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cpu_start_n && !cs0_n && cs1 && !cs2_n) |=> rd_q);

   // R8
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cycle |=> !rd_q);

   // R10
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!rd_q && $stable(beat) && $stable(upper)));
endmodule

bind fts_sram fts_chk #(.AW(AW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep       (sleep),
   .cpu_start_n (cpu_start_n),
   .ctl_start_n (ctl_start_n),
   .burst_adv_n (burst_adv_n),
   .cs0_n       (cs0_n),
   .cs1         (cs1),
   .cs2_n       (cs2_n),
   .beat        (burst_beat),
   .upper       (burst_upper),
   .rd_q        (rd_q),
   .wr_cycle    (wr_cycle)
);

// File: tb/test_fts_sram.sv
module test_fts_sram;
   localparam int CLK_P = 10;
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int DW    = 36;
   localparam logic [DW-1:0] FLOAT = '1;

   logic clk = 1'b0;
   logic rst_n;
   logic [AW-1:0] addr;
   logic cs0_n, cs1, cs2_n, cpu_start_n, ctl_start_n, burst_adv_n;
   logic wr_all_n, wr_lane_en_n, order_il, out_en_n, sleep;
   logic [3:0] lane_sel_n;
   logic tb_oe;
   logic [DW-1:0] tb_wd;
   tri1 [DW-1:0] dq;

   logic [DW-1:0] model [DEPTH];
   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   assign dq = tb_oe ? tb_wd : {DW{1'bz}};

   always #(CLK_P/2) clk = ~clk;

   fts_sram #(.AW(AW)) i_fts_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq),
      .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
      .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
      .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n),
      .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .order_il(order_il), .out_en_n(out_en_n), .sleep(sleep)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      logic [DW-1:0] w;
      for (int i = 0; i < 4; i++) w[i*9 +: 9] = 9'((a*7 + i*37 + salt*29) & 8'hFF);
      return w;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_start_n = 1; ctl_start_n = 1; burst_adv_n = 1;
      wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = '1;
      cs0_n = 0; cs1 = 1; cs2_n = 0; tb_oe = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic read_start(input int a);
      idle(); out_en_n = 0; cpu_start_n = 0; addr = AW'(a);
      step();
   endtask

   initial begin
      #(CLK_P*100000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle(); addr = '0; order_il = 0; out_en_n = 0; sleep = 0; tb_wd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: nothing driven after reset
      chk("R11", dq, FLOAT);

      // R7 R1: fill every word with all-lane writes
      for (int a = 0; a < DEPTH; a++) begin
         idle(); out_en_n = 1; ctl_start_n = 0; wr_all_n = 0; addr = AW'(a);
         tb_oe = 1; tb_wd = pat(a, 0); model[a] = pat(a, 0);
         step();
      end

      // R3 R4 R5 R1: every start offset, both orders, 2-1-1-1 flow-through
      for (int ord = 0; ord < 2; ord++) begin
         for (int s = 0; s < DEPTH; s++) begin
            order_il = ord[0];
            read_start(s);
            chk("R5", dq, model[s]);
            for (int b = 1; b < 4; b++) begin
               int lo, ea;
               idle(); out_en_n = 0; burst_adv_n = 0; addr = ~AW'(s);
               step();
               lo = ord ? ((s & 3) ^ b) : (((s & 3) + b) % 4);
               ea = (s & ~3) | lo;
               chk(ord ? "R4 interleaved" : "R4 linear", dq, model[ea]);
            end
         end
      end

      // R3: hold while advance is high
      order_il = 0;
      read_start(5);
      chk("R3", dq, model[5]);
      idle(); out_en_n = 0; step();
      chk("R3 hold", dq, model[5]);
      burst_adv_n = 0; step();
      chk("R3 step", dq, model[6]);

      // R7: lane-masked write bursts, all sixteen masks
      for (int m = 0; m < 16; m++) begin
         for (int b = 0; b < 4; b++) begin
            int ea;
            ea = m * 4 + b;
            idle(); out_en_n = 1; wr_lane_en_n = 0; lane_sel_n = 4'(m);
            if (b == 0) begin
               ctl_start_n = 0; addr = AW'(m * 4);
            end else begin
               burst_adv_n = 0;
            end
            tb_oe = 1; tb_wd = pat(ea, 1 + m);
            for (int i = 0; i < 4; i++)
               if (!m[i]) model[ea][i*9 +: 9] = tb_wd[i*9 +: 9];
            step();
         end
      end
      for (int a = 0; a < DEPTH; a++) begin
         read_start(a);
         chk("R7 lanes", dq, model[a]);
      end

      // R2: every failing select combination floats and writes nothing
      for (int c = 0; c < 8; c++) begin
         if (c != 3'b010) begin
            idle(); out_en_n = 1; ctl_start_n = 0; wr_all_n = 0; addr = 10;
            {cs0_n, cs1, cs2_n} = 3'(c); tb_oe = 1; tb_wd = pat(10, 9);
            step();
            idle(); out_en_n = 0; cpu_start_n = 0; addr = 10;
            {cs0_n, cs1, cs2_n} = 3'(c);
            step();
            chk("R2 float", dq, FLOAT);
         end
      end
      read_start(10);
      chk("R2 kept", dq, model[10]);

      // R7: lane selects without the lane enable do not write
      idle(); out_en_n = 1; ctl_start_n = 0; lane_sel_n = 4'h0; addr = 11;
      tb_oe = 1; tb_wd = pat(11, 13);
      step();
      read_start(11);
      chk("R7 no enable", dq, model[11]);

      // R6: both strobes with write enables is a read
      idle(); out_en_n = 1; cpu_start_n = 0; ctl_start_n = 0; wr_all_n = 0; addr = 12;
      tb_oe = 1; tb_wd = pat(12, 17);
      step();
      idle(); out_en_n = 0; #1;
      chk("R6", dq, model[12]);

      // R8: cycle after a write is undriven, then the word reads back
      idle(); out_en_n = 1; ctl_start_n = 0; wr_all_n = 0; addr = 13;
      tb_oe = 1; tb_wd = pat(13, 21); model[13] = pat(13, 21);
      step();
      idle(); out_en_n = 0; #1;
      chk("R8", dq, FLOAT);
      step();
      chk("R8 readback", dq, model[13]);

      // R9: output enable acts between edges
      read_start(14);
      chk("R9", dq, model[14]);
      out_en_n = 1; #1;
      chk("R9 off", dq, FLOAT);
      out_en_n = 0; #1;
      chk("R9 on", dq, model[14]);

      // R10: sleep floats at once, blocks writes and freezes the counter
      read_start(15);
      sleep = 1; #1;
      chk("R10 float", dq, FLOAT);
      idle(); out_en_n = 1; ctl_start_n = 0; wr_all_n = 0; addr = 15;
      tb_oe = 1; tb_wd = pat(15, 25);
      step();
      idle(); step();
      sleep = 0;
      read_start(15);
      chk("R10 kept", dq, model[15]);
      read_start(16);
      chk("R10 start", dq, model[16]);
      sleep = 1; idle(); out_en_n = 0; burst_adv_n = 0;
      step(); step();
      sleep = 0; burst_adv_n = 1;
      step();
      chk("R10 counter", dq, model[16]);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule